// File: doc/BRIEF.md
# Interrupt Vector Address Generator

This block turns an exception or interrupt number into the byte address of its entry in a vector table. Each entry is one 32-bit word, so entry `n` lies at byte offset `4*n` from the table base; entry 0 is the slot that holds the initial stack pointer. Software sets the table base through a small write port and can read it back at any time. The lowest seven bits of the base do not exist and always read as zero.

A requester presents a vector number with a valid strobe. One clock later the block returns the fetch address with its own strobe. A number outside the table gets an error pulse instead. A build-time parameter chooses how the base and the scaled offset are combined: bitwise OR, or true addition. With OR, a base that is aligned only to the 128-byte register granularity, and not to the full table span, makes some vectors alias onto the slots of other vectors. A status output shows when the base has set bits between the register granularity and the table-size alignment. For the default table of 111 entries that span is 0x200.

Top module: `vecgen_top`

## Requirements
- R1: After synchronous reset the base reads back as 0x00000000, `addr_valid`, `req_err` and `base_misaligned` are low, and vector `n` maps to address `4*n`.
- R2: A write stores the data with bits 6:0 forced to zero. Writing 0xFFFFFFFF reads back 0xFFFFFF80, and the readback always reflects the last write.
- R3: Vector entry `n` occupies byte offset `4*n` above the base, so every vector number below the table size produces an address whose bits 1:0 equal those of the base, which are zero.
- R4: In OR mode the address is `base | (4*n)`. With base 0x8080, vector 61 gives 0x80F4 and vector 89 gives 0x81E4. With base 0x8100, vector 89 gives 0x8164 and vector 61 gives 0x81F4.
- R5: In add mode the address is `(base + 4*n)` modulo 2^32. With base 0x8080, vector 61 gives 0x8174. With base 0x8100, vector 89 gives 0x8264.
- R6: With a base whose bits 8:7 are zero, both modes give identical addresses for every vector. For example, base 0x8000 gives 0x8164 for vector 89 and 0x80F4 for vector 61.
- R7: A request with a vector number of 111 or above raises `req_err` for exactly one cycle, one clock after the request, produces no `addr_valid`, and leaves `addr_out` unchanged.
- R8: An in-range request raises `addr_valid` for exactly one cycle, one clock after it is accepted. Without a request, neither `addr_valid` nor `req_err` is raised.
- R9: A base write takes effect for requests accepted from the next cycle on. A request presented in the same cycle as a write uses the previous base.
- R10: `base_misaligned` is high exactly when base bits 8:7 are not both zero. It has no effect on the computed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the base register |
| reg_wr_data | input | 32 | Base value to write |
| reg_rd_data | output | 32 | Current base, bits 6:0 read as zero |
| req_valid | input | 1 | Vector request strobe |
| req_vec | input | 7 | Requested vector number |
| addr_valid | output | 1 | One-cycle strobe: `addr_out` holds a new address |
| addr_out | output | 32 | Vector entry byte address |
| req_err | output | 1 | One-cycle strobe: requested number was out of range |
| base_misaligned | output | 1 | Base not aligned to the table span |

## Verification
The bench builds two copies of the block with the default 111-entry table, one in OR mode and one in add mode. Both copies see the same stimulus, so every request shows in a single cycle where the two combining rules agree and where they split. Because the vector field is seven bits wide, all 128 numbers can be swept for each base. That sweep covers every in-range entry and all seventeen out-of-range codes. The bases include fully aligned values, values offset by one and two granularity steps, and the all-ones base, where addition wraps around 2^32.

// File: rtl/vecgen_pkg.sv
package vecgen_pkg;

    // Address and data width of the base register and the fetch address.
    localparam int ADDR_W = 32;

    // Bytes per vector entry, expressed as a left shift.
    localparam int ENTRY_SHIFT = 2;

    // How the base and the scaled offset are merged.
    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_ADD = 1'b1
    } combine_e;

    // Registered response of one request.
    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } resp_t;

    // Mask that clears the unimplemented low bits of the base.
    function automatic logic [ADDR_W-1:0] base_mask(input int lsb);
        logic [ADDR_W-1:0] m;
        m = '1;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < lsb) m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/vecgen_base_reg.sv
module vecgen_base_reg
    import vecgen_pkg::*;
#(
    parameter int BASE_LSB  = 7,
    parameter int ALIGN_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base,
    output logic              misaligned
);

    localparam logic [ADDR_W-1:0] MASK = base_mask(BASE_LSB);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data & MASK;
        end
    end

    assign base = base_q;

    // Bits between the register granularity and the table span.
    generate
        if (ALIGN_LSB > BASE_LSB) begin : g_gap
            assign misaligned = |base_q[ALIGN_LSB-1:BASE_LSB];
        end else begin : g_nogap
            assign misaligned = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/vecgen_addr_calc.sv
module vecgen_addr_calc
    import vecgen_pkg::*;
#(
    parameter int       VEC_W   = 7,
    parameter int       NUM_VEC = 111,
    parameter combine_e MODE    = COMB_OR
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    localparam int PAD_W = ADDR_W - VEC_W - ENTRY_SHIFT;
    localparam logic [VEC_W:0] LIMIT = (VEC_W + 1)'(NUM_VEC);

    logic [ADDR_W-1:0] offset;

    assign offset   = {{PAD_W{1'b0}}, vec, {ENTRY_SHIFT{1'b0}}};
    assign in_range = {1'b0, vec} < LIMIT;

    generate
        if (MODE == COMB_OR) begin : g_or
            assign addr = base | offset;
        end else begin : g_add
            assign addr = base + offset;
        end
    endgenerate

endmodule

// File: rtl/vecgen_resp_stage.sv
module vecgen_resp_stage
    import vecgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              in_range,
    input  logic [ADDR_W-1:0] addr_next,
    output resp_t             resp
);

    resp_t resp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= req_valid && in_range;
            resp_q.err   <= req_valid && !in_range;
            if (req_valid && in_range) begin
                resp_q.addr <= addr_next;
            end
        end
    end

    assign resp = resp_q;

endmodule

// File: rtl/vecgen_top.sv
module vecgen_top
    import vecgen_pkg::*;
#(
    parameter int       NUM_VEC  = 111,
    parameter int       BASE_LSB = 7,
    parameter combine_e MODE     = COMB_OR,
    parameter int       VEC_W    = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    output logic              addr_valid,
    output logic [31:0]       addr_out,
    output logic              req_err,
    output logic              base_misaligned
);

    // Table span in bytes, rounded up to a power of two.
    localparam int ALIGN_LSB = $clog2(NUM_VEC) + ENTRY_SHIFT;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] addr_next;
    logic              in_range;
    resp_t             resp;

    vecgen_base_reg #(
        .BASE_LSB (BASE_LSB),
        .ALIGN_LSB(ALIGN_LSB)
    ) u_base (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .base      (base),
        .misaligned(base_misaligned)
    );

    vecgen_addr_calc #(
        .VEC_W  (VEC_W),
        .NUM_VEC(NUM_VEC),
        .MODE   (MODE)
    ) u_calc (
        .base    (base),
        .vec     (req_vec),
        .addr    (addr_next),
        .in_range(in_range)
    );

    vecgen_resp_stage u_resp (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .in_range (in_range),
        .addr_next(addr_next),
        .resp     (resp)
    );

    assign reg_rd_data = base;
    assign addr_valid  = resp.valid;
    assign req_err     = resp.err;
    assign addr_out    = resp.addr;

endmodule

// File: rtl/vecgen_checker.sv
module vecgen_checker
    import vecgen_pkg::*;
#(
    parameter int       NUM_VEC  = 111,
    parameter int       BASE_LSB = 7,
    parameter combine_e MODE     = COMB_OR,
    parameter int       VEC_W    = $clog2(NUM_VEC)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [31:0]      reg_wr_data,
    input logic [31:0]      reg_rd_data,
    input logic             req_valid,
    input logic [VEC_W-1:0] req_vec,
    input logic             addr_valid,
    input logic [31:0]      addr_out,
    input logic             req_err,
    input logic             base_misaligned
);

    localparam int ALIGN_LSB = $clog2(NUM_VEC) + ENTRY_SHIFT;
    localparam logic [31:0] MASK = base_mask(BASE_LSB);
    localparam logic [VEC_W:0] LIMIT = (VEC_W + 1)'(NUM_VEC);

    logic [31:0] offs;
    logic        ok_vec;
    assign offs   = {{(32 - VEC_W - ENTRY_SHIFT){1'b0}}, req_vec, {ENTRY_SHIFT{1'b0}}};
    assign ok_vec = {1'b0, req_vec} < LIMIT;

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & MASK));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_en |=> $stable(reg_rd_data));

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ok_vec) |=> (addr_valid && !req_err));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!addr_valid && !req_err));

    p_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ok_vec) |=> (req_err && !addr_valid && $stable(addr_out)));

    p_flag_r10: assert property (@(posedge clk) disable iff (rst)
        base_misaligned == (reg_rd_data[ALIGN_LSB-1:BASE_LSB] != '0));

    generate
        if (MODE == COMB_OR) begin : g_or
            p_or_r4: assert property (@(posedge clk) disable iff (rst)
                (req_valid && ok_vec) |=> addr_out == ($past(reg_rd_data) | $past(offs)));
        end else begin : g_add
            p_add_r5: assert property (@(posedge clk) disable iff (rst)
                (req_valid && ok_vec) |=> addr_out == ($past(reg_rd_data) + $past(offs)));
        end
    endgenerate

endmodule

bind vecgen_top vecgen_checker #(
    .NUM_VEC (NUM_VEC),
    .BASE_LSB(BASE_LSB),
    .MODE    (MODE),
    .VEC_W   (VEC_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .req_valid      (req_valid),
    .req_vec        (req_vec),
    .addr_valid     (addr_valid),
    .addr_out       (addr_out),
    .req_err        (req_err),
    .base_misaligned(base_misaligned)
);

// File: tb/vecgen_top_tb.sv
module vecgen_top_tb;
    import vecgen_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_VEC    = 111;
    localparam int VEC_W      = 7;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_vec = '0;

    logic [31:0] rd_or, rd_add, a_or, a_add;
    logic        v_or, v_add, e_or, e_add, m_or, m_add;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] last_or = '0;
    logic [31:0] last_add = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vecgen_top #(.NUM_VEC(NUM_VEC), .MODE(COMB_OR)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
        .reg_rd_data(rd_or), .req_valid(req_valid), .req_vec(req_vec),
        .addr_valid(v_or), .addr_out(a_or), .req_err(e_or),
        .base_misaligned(m_or)
    );

    vecgen_top #(.NUM_VEC(NUM_VEC), .MODE(COMB_ADD)) u_dut_add (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
        .reg_rd_data(rd_add), .req_valid(req_valid), .req_vec(req_vec),
        .addr_valid(v_add), .addr_out(a_add), .req_err(e_add),
        .base_misaligned(m_add)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_base(input logic [31:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Issue one request, sample both copies one clock later.
    task automatic request(input int v, input logic [31:0] base, input string tag);
        logic [31:0] off;
        bit          ok;
        off = 32'(v) << 2;
        ok  = v < NUM_VEC;
        @(negedge clk);
        req_valid = 1'b1;
        req_vec   = 7'(v);
        @(negedge clk);
        req_valid = 1'b0;
        if (ok) begin
            check({tag, " R8 valid or"}, 32'(v_or), 32'd1);
            check({tag, " R8 valid add"}, 32'(v_add), 32'd1);
            check({tag, " R4 addr or"}, a_or, base | off);
            check({tag, " R5 addr add"}, a_add, base + off);
            last_or  = base | off;
            last_add = base + off;
        end else begin
            check({tag, " R7 err or"}, {30'd0, v_or, e_or}, 32'd1);
            check({tag, " R7 err add"}, {30'd0, v_add, e_add}, 32'd1);
            check({tag, " R7 addr kept or"}, a_or, last_or);
            check({tag, " R7 addr kept add"}, a_add, last_add);
        end
        @(negedge clk);
        check({tag, " R8 R7 single pulse"}, {28'd0, v_or, v_add, e_or, e_add}, 32'd0);
    endtask

    task automatic sweep(input logic [31:0] raw);
        logic [31:0] b;
        b = raw & 32'hFFFF_FF80;
        write_base(raw);
        check("R2 readback or", rd_or, b);
        check("R2 readback add", rd_add, b);
        check("R10 flag or", 32'(m_or), 32'(b[8:7] != 2'b00));
        check("R10 flag add", 32'(m_add), 32'(b[8:7] != 2'b00));
        for (int v = 0; v < 128; v++) begin
            request(v, b, "sweep");
            if (v < NUM_VEC && b[8:7] == 2'b00)
                check("R6 modes agree", a_or, a_add);
            if (v < NUM_VEC)
                check("R3 word aligned", {30'd0, a_or[1:0]}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 base or", rd_or, 32'h0);
        check("R1 base add", rd_add, 32'h0);
        check("R1 outputs", {27'd0, v_or, v_add, e_or, e_add, m_or}, 32'd0);
        check("R1 idle flag add", 32'(m_add), 32'd0);
        request(89, 32'h0, "R1 R3 reset base");

        // Spot values for the aliasing cases.
        write_base(32'h0000_8080);
        request(61, 32'h8080, "spot");
        check("R4 v61 base8080", a_or, 32'h80F4);
        check("R5 v61 base8080", a_add, 32'h8174);
        request(89, 32'h8080, "spot");
        check("R4 v89 base8080", a_or, 32'h81E4);
        check("R5 v89 base8080", a_add, 32'h81E4);
        check("R10 flag 8080", 32'(m_or), 32'd1);

        write_base(32'h0000_8100);
        request(89, 32'h8100, "spot");
        check("R4 v89 base8100", a_or, 32'h8164);
        check("R5 v89 base8100", a_add, 32'h8264);
        request(61, 32'h8100, "spot");
        check("R4 v61 base8100", a_or, 32'h81F4);

        write_base(32'h0000_8000);
        request(89, 32'h8000, "spot");
        check("R6 v89 base8000", {a_or ^ a_add} | (a_or ^ 32'h8164), 32'h0);
        request(61, 32'h8000, "spot");
        check("R6 v61 base8000", {a_or ^ a_add} | (a_or ^ 32'h80F4), 32'h0);

        // R9: same-cycle write and request uses the old base.
        write_base(32'h0000_8100);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_8080;
        req_valid = 1'b1; req_vec = 7'd61;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 old base or", a_or, 32'h81F4);
        check("R9 old base add", a_add, 32'h81F4);
        req_vec = 7'd61;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 new base or", a_or, 32'h80F4);
        check("R9 new base add", a_add, 32'h8174);
        last_or = 32'h80F4; last_add = 32'h8174;

        write_base(32'hFFFF_FFFF);
        check("R2 all ones", rd_or, 32'hFFFF_FF80);

        sweep(32'h0000_8000);
        sweep(32'h0000_8080);
        sweep(32'h0000_8100);
        sweep(32'h0000_8180);
        sweep(32'hFFFF_FFFF);
        sweep(32'h1234_567F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule